// File: doc/BRIEF.md
# Multiframe Descriptor Service Controller

This block manages the two directions of a framed serial link core. The core moves data one 16-frame multiframe at a time, and it needs buffer descriptors to do so. For each direction the controller keeps a lifecycle state and a count of descriptors currently held by the core. It keeps no more than four outstanding. It takes back descriptors the core has finished with, and it reacts to alignment loss, receive overflow and transmit underflow by running a recovery sequence.

Work happens in service passes. A one-cycle `tick` starts a pass, and the pass then steps through fixed phases, one cycle per action:

1. Retire transmit completions.
2. Retire receive completions.
3. Apply the transmit boot gate.
4. Check receive errors and recover if needed.
5. Refill receive descriptors.
6. Close receive.
7. Check transmit errors and apply the recover gate.
8. Refill transmit descriptors.
9. Close transmit.

The ring trackers are outside the block. They supply a grant level or an unseen-frame level, plus the current frame offset. The controller sends them strobes to allocate, commit, peek, discard and flush multiframes.

Direction states are Idle (0), Boot (1), Run (2) and Recover (3). The transitions are:
- Idle→Boot and any→Boot on `start`.
- Boot→Run and Recover→Run when a pass closes that direction.
- Run→Recover on alignment loss or overflow (receive), or on underflow (transmit).

Top module: `dsc_top`

## Requirements
- R1: After reset both direction states read 0 (Idle). A `start` pulse sets both to 1 (Boot) on the next cycle and clears both in-flight counts. A `tick` while both directions are Idle produces no strobe.
- R2: A direction never has more than 4 descriptors in flight. A receive push happens only while `rx_mf_grant` is high. A transmit push happens only while `tx_unseen` is at least 16.
- R3: A returned descriptor is complete when bit 15 is set. Popping a receive descriptor strobes `rx_mf_commit` in the same cycle. Popping a transmit descriptor strobes `tx_mf_discard` in the same cycle. Each pop lowers that direction's in-flight count by one.
- R4: Receive CRC is good only if returned bits 14 and 13 are both 1. Any other value pulses `rx_crc_bad` together with the pop.
- R5: While transmit is in Boot and `tx_unseen` is below 80, a pass stops right after retirement: no descriptor is pushed in either direction and no state changes.
- R6: Receive in Run moves to Recover (3) when `rx_aligned` is low or `rx_ovfl` is high at its check phase.
- R7: Receive in Recover with descriptors still in flight does nothing more in that pass: no flush, push or clear. Once the count is zero, the pass pulses `rx_ring_flush` once, refills, clears and returns to Run.
- R8: Transmit in Run moves to Recover (3) when `tx_unfl` is high. In Recover, the transmit part of a pass stops until `tx_unseen` is at least 80. Receive servicing earlier in the same pass is unaffected.
- R9: When a pass closes a direction that is not in Run, it pulses that direction's sticky-clear output (`rx_ovfl_clr` or `tx_unfl_clr`) exactly once and the direction enters Run (2).
- R10: The descriptor address is the frame offset shifted right by 4. Ring wrap is included, so offset 0 gives address 0.
- R11: In every pass, completions are retired before refill, so descriptors freed in a pass are reissued in that same pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Put both directions into Boot |
| tick | input | 1 | Start one service pass |
| rx_aligned | input | 1 | Receive framing aligned |
| rx_ovfl | input | 1 | Sticky receive overflow flag |
| tx_unfl | input | 1 | Sticky transmit underflow flag |
| rx_ret_bd | input | 16 | Head of receive completion queue |
| rx_ret_pop | output | 1 | Pop receive completion |
| tx_ret_bd | input | 16 | Head of transmit completion queue |
| tx_ret_pop | output | 1 | Pop transmit completion |
| rx_mf_grant | input | 1 | Receive ring has a free multiframe |
| rx_wr_ofs | input | OFS_W | Receive ring next write frame offset |
| tx_unseen | input | LVL_W | Transmit ring unseen frame count |
| tx_rd_ofs | input | OFS_W | Transmit ring next peek frame offset |
| rx_bd_push | output | 1 | Issue receive descriptor |
| rx_bd_addr | output | OFS_W-4 | Receive descriptor multiframe address |
| tx_bd_push | output | 1 | Issue transmit descriptor |
| tx_bd_addr | output | OFS_W-4 | Transmit descriptor multiframe address |
| rx_mf_alloc | output | 1 | Allocate receive multiframe |
| rx_mf_commit | output | 1 | Commit receive multiframe |
| rx_ring_flush | output | 1 | Empty receive ring |
| tx_mf_peek | output | 1 | Peek transmit multiframe |
| tx_mf_discard | output | 1 | Discard transmit multiframe |
| rx_ovfl_clr | output | 1 | Clear receive overflow flag |
| tx_unfl_clr | output | 1 | Clear transmit underflow flag |
| rx_crc_bad | output | 1 | Retired receive descriptor had a CRC failure |
| rx_state | output | 2 | Receive direction state |
| tx_state | output | 2 | Transmit direction state |

## Verification
A wrong in-flight count shows up at the next pass. Either too many pushes appear (more than four outstanding), or refill stalls and the core starves, or recovery never flushes because the count never reaches zero. A wrong direction state shows directly on `rx_state` or `tx_state` one cycle after the phase that should have changed it. It also shows as a missing or extra clear pulse within the same pass. The bench counts strobes across each pass against expected totals and checks the last issued address. As a result, a broken phase order or gating is visible within one pass of the stimulus.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [1:0] {
        DS_IDLE    = 2'd0,
        DS_BOOT    = 2'd1,
        DS_RUN     = 2'd2,
        DS_RECOVER = 2'd3
    } dir_state_e;

    typedef enum logic [3:0] {
        SQ_WAIT,
        SQ_TX_RETIRE,
        SQ_RX_RETIRE,
        SQ_BOOT_GATE,
        SQ_RX_CHECK,
        SQ_RX_FILL,
        SQ_RX_CLOSE,
        SQ_TX_CHECK,
        SQ_TX_FILL,
        SQ_TX_CLOSE
    } seq_state_e;

    // Returned descriptor bit positions (decoded by the core side)
    localparam int BD_W        = 16;
    localparam int BD_DONE_BIT = 15;
    localparam int BD_CRC1_BIT = 14;
    localparam int BD_CRC0_BIT = 13;

endpackage

// File: rtl/dsc_inflight.sv
module dsc_inflight #(
    parameter int MAX   = 4,
    parameter int CNT_W = $clog2(MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign count = cnt_q;
    assign full  = (cnt_q == CNT_W'(MAX));
    assign empty = (cnt_q == '0);

    p_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX));
    p_no_inc_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clear) |-> cnt_q < CNT_W'(MAX));
    p_no_dec_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !clear) |-> cnt_q != '0);

endmodule

// File: rtl/dsc_dir_fsm.sv
module dsc_dir_fsm
    import dsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       go_recover,
    input  logic       go_run,
    output dir_state_e state
);

    dir_state_e state_q;
    dir_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (start)           state_d = DS_BOOT;
        else if (go_recover) state_d = DS_RECOVER;
        else if (go_run)     state_d = DS_RUN;
    end

    assign state = state_q;

    // R6 / R8: Recover is only ever entered from Run
    p_recover_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DS_RECOVER && $past(state_q) != DS_RECOVER)
            |-> ($past(state_q) == DS_RUN));

endmodule

// File: rtl/dsc_pass_seq.sv
module dsc_pass_seq
    import dsc_pkg::*;
#(
    parameter int LVL_W      = 8,
    parameter int MF_FRAMES  = 16,
    parameter int PREFILL_MF = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    input  dir_state_e       rx_state,
    input  dir_state_e       tx_state,
    input  logic             rx_full,
    input  logic             rx_empty,
    input  logic             tx_full,
    input  logic             rx_ret_valid,
    input  logic             rx_crc_ok,
    input  logic             tx_ret_valid,
    input  logic             rx_aligned,
    input  logic             rx_ovfl,
    input  logic             tx_unfl,
    input  logic             rx_grant,
    input  logic [LVL_W-1:0] tx_unseen,
    output logic             rx_pop,
    output logic             tx_pop,
    output logic             rx_crc_bad,
    output logic             rx_push,
    output logic             tx_push,
    output logic             rx_flush,
    output logic             rx_clr,
    output logic             tx_clr,
    output logic             rx_go_rec,
    output logic             tx_go_rec,
    output logic             rx_go_run,
    output logic             tx_go_run
);

    localparam int PREFILL_FRAMES = PREFILL_MF * MF_FRAMES;

    seq_state_e cur_q;
    seq_state_e nxt;

    logic tx_prefilled;
    logic tx_can_peek;
    logic both_idle;
    logic rx_in_rec;
    logic tx_in_rec;

    assign tx_prefilled = (tx_unseen >= LVL_W'(PREFILL_FRAMES));
    assign tx_can_peek  = (tx_unseen >= LVL_W'(MF_FRAMES));
    assign both_idle    = (rx_state == DS_IDLE) && (tx_state == DS_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= SQ_WAIT;
        else        cur_q <= nxt;
    end

    always_comb begin
        nxt        = cur_q;
        rx_pop     = 1'b0;
        tx_pop     = 1'b0;
        rx_crc_bad = 1'b0;
        rx_push    = 1'b0;
        tx_push    = 1'b0;
        rx_flush   = 1'b0;
        rx_clr     = 1'b0;
        tx_clr     = 1'b0;
        rx_go_rec  = 1'b0;
        tx_go_rec  = 1'b0;
        rx_go_run  = 1'b0;
        tx_go_run  = 1'b0;
        rx_in_rec  = 1'b0;
        tx_in_rec  = 1'b0;
        unique case (cur_q)
            SQ_WAIT: begin
                if (tick && !both_idle) nxt = SQ_TX_RETIRE;
            end
            SQ_TX_RETIRE: begin
                if (tx_ret_valid) tx_pop = 1'b1;
                else              nxt    = SQ_RX_RETIRE;
            end
            SQ_RX_RETIRE: begin
                if (rx_ret_valid) begin
                    rx_pop     = 1'b1;
                    rx_crc_bad = !rx_crc_ok;
                end else begin
                    nxt = SQ_BOOT_GATE;
                end
            end
            SQ_BOOT_GATE: begin
                if (tx_state == DS_BOOT && !tx_prefilled) nxt = SQ_WAIT;
                else                                      nxt = SQ_RX_CHECK;
            end
            SQ_RX_CHECK: begin
                rx_go_rec = (rx_state == DS_RUN) && (!rx_aligned || rx_ovfl);
                rx_in_rec = rx_go_rec || (rx_state == DS_RECOVER);
                if (rx_in_rec && !rx_empty) begin
                    nxt = SQ_TX_CHECK;
                end else begin
                    rx_flush = rx_in_rec;
                    nxt      = SQ_RX_FILL;
                end
            end
            SQ_RX_FILL: begin
                if (!rx_full && rx_grant) rx_push = 1'b1;
                else                      nxt     = SQ_RX_CLOSE;
            end
            SQ_RX_CLOSE: begin
                if (rx_state != DS_RUN) begin
                    rx_clr    = 1'b1;
                    rx_go_run = 1'b1;
                end
                nxt = SQ_TX_CHECK;
            end
            SQ_TX_CHECK: begin
                tx_go_rec = (tx_state == DS_RUN) && tx_unfl;
                tx_in_rec = tx_go_rec || (tx_state == DS_RECOVER);
                if (tx_in_rec && !tx_prefilled) nxt = SQ_WAIT;
                else                            nxt = SQ_TX_FILL;
            end
            SQ_TX_FILL: begin
                if (!tx_full && tx_can_peek) tx_push = 1'b1;
                else                         nxt     = SQ_TX_CLOSE;
            end
            SQ_TX_CLOSE: begin
                if (tx_state != DS_RUN) begin
                    tx_clr    = 1'b1;
                    tx_go_run = 1'b1;
                end
                nxt = SQ_WAIT;
            end
            default: nxt = SQ_WAIT;
        endcase
        if (start) nxt = SQ_WAIT;
    end

    // R11: refill never starts before both retirement phases have run dry
    p_retire_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == SQ_BOOT_GATE) |-> $past(cur_q) == SQ_RX_RETIRE);

endmodule

// File: rtl/dsc_top.sv
module dsc_top
    import dsc_pkg::*;
#(
    parameter int MAX_INFLIGHT = 4,
    parameter int OFS_W        = 11,
    parameter int LVL_W        = 8,
    parameter int MF_FRAMES    = 16,
    parameter int PREFILL_MF   = 5
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start,
    input  logic                                tick,
    input  logic                                rx_aligned,
    input  logic                                rx_ovfl,
    input  logic                                tx_unfl,
    input  logic [15:0]                         rx_ret_bd,
    output logic                                rx_ret_pop,
    input  logic [15:0]                         tx_ret_bd,
    output logic                                tx_ret_pop,
    input  logic                                rx_mf_grant,
    input  logic [OFS_W-1:0]                    rx_wr_ofs,
    input  logic [LVL_W-1:0]                    tx_unseen,
    input  logic [OFS_W-1:0]                    tx_rd_ofs,
    output logic                                rx_bd_push,
    output logic [OFS_W-$clog2(MF_FRAMES)-1:0]  rx_bd_addr,
    output logic                                tx_bd_push,
    output logic [OFS_W-$clog2(MF_FRAMES)-1:0]  tx_bd_addr,
    output logic                                rx_mf_alloc,
    output logic                                rx_mf_commit,
    output logic                                rx_ring_flush,
    output logic                                tx_mf_peek,
    output logic                                tx_mf_discard,
    output logic                                rx_ovfl_clr,
    output logic                                tx_unfl_clr,
    output logic                                rx_crc_bad,
    output logic [1:0]                          rx_state,
    output logic [1:0]                          tx_state
);

    localparam int MF_SHIFT = $clog2(MF_FRAMES);
    localparam int CNT_W    = $clog2(MAX_INFLIGHT + 1);

    dir_state_e       rx_st, tx_st;
    logic [CNT_W-1:0] rx_cnt, tx_cnt;
    logic             rx_full, rx_empty, tx_full, tx_empty;
    logic             rx_pop, tx_pop, rx_push, tx_push;
    logic             rx_go_rec, tx_go_rec, rx_go_run, tx_go_run;
    logic             rx_clr, tx_clr, rx_flush, crc_bad;
    logic             rx_crc_ok;

    assign rx_crc_ok = rx_ret_bd[BD_CRC1_BIT] & rx_ret_bd[BD_CRC0_BIT];

    dsc_pass_seq #(
        .LVL_W      (LVL_W),
        .MF_FRAMES  (MF_FRAMES),
        .PREFILL_MF (PREFILL_MF)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .tick         (tick),
        .rx_state     (rx_st),
        .tx_state     (tx_st),
        .rx_full      (rx_full),
        .rx_empty     (rx_empty),
        .tx_full      (tx_full),
        .rx_ret_valid (rx_ret_bd[BD_DONE_BIT]),
        .rx_crc_ok    (rx_crc_ok),
        .tx_ret_valid (tx_ret_bd[BD_DONE_BIT]),
        .rx_aligned   (rx_aligned),
        .rx_ovfl      (rx_ovfl),
        .tx_unfl      (tx_unfl),
        .rx_grant     (rx_mf_grant),
        .tx_unseen    (tx_unseen),
        .rx_pop       (rx_pop),
        .tx_pop       (tx_pop),
        .rx_crc_bad   (crc_bad),
        .rx_push      (rx_push),
        .tx_push      (tx_push),
        .rx_flush     (rx_flush),
        .rx_clr       (rx_clr),
        .tx_clr       (tx_clr),
        .rx_go_rec    (rx_go_rec),
        .tx_go_rec    (tx_go_rec),
        .rx_go_run    (rx_go_run),
        .tx_go_run    (tx_go_run)
    );

    dsc_dir_fsm u_rx_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .go_recover (rx_go_rec),
        .go_run     (rx_go_run),
        .state      (rx_st)
    );

    dsc_dir_fsm u_tx_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .go_recover (tx_go_rec),
        .go_run     (tx_go_run),
        .state      (tx_st)
    );

    dsc_inflight #(.MAX(MAX_INFLIGHT), .CNT_W(CNT_W)) u_rx_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .inc   (rx_push),
        .dec   (rx_pop),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    dsc_inflight #(.MAX(MAX_INFLIGHT), .CNT_W(CNT_W)) u_tx_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .inc   (tx_push),
        .dec   (tx_pop),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    assign rx_ret_pop    = rx_pop;
    assign rx_mf_commit  = rx_pop;
    assign tx_ret_pop    = tx_pop;
    assign tx_mf_discard = tx_pop;
    assign rx_bd_push    = rx_push;
    assign rx_mf_alloc   = rx_push;
    assign tx_bd_push    = tx_push;
    assign tx_mf_peek    = tx_push;
    assign rx_bd_addr    = rx_wr_ofs[OFS_W-1:MF_SHIFT];
    assign tx_bd_addr    = tx_rd_ofs[OFS_W-1:MF_SHIFT];
    assign rx_ring_flush = rx_flush;
    assign rx_ovfl_clr   = rx_clr;
    assign tx_unfl_clr   = tx_clr;
    assign rx_crc_bad    = crc_bad;
    assign rx_state      = rx_st;
    assign tx_state      = tx_st;

    p_start_boot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (rx_st == DS_BOOT && tx_st == DS_BOOT));
    p_rx_push_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bd_push |-> rx_mf_grant);
    p_pop_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ret_pop |-> rx_ret_bd[BD_DONE_BIT]) and (tx_ret_pop |-> tx_ret_bd[BD_DONE_BIT]));
    p_flush_drained_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ring_flush |-> (rx_cnt == '0));
    p_rx_clr_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovfl_clr |=> (rx_st == DS_RUN));
    p_tx_clr_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_unfl_clr |=> (tx_st == DS_RUN));
    p_single_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_bd_push, tx_bd_push, rx_ret_pop, tx_ret_pop}));

endmodule

// File: tb/tb_dsc_top.sv
module tb_dsc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        tick = 1'b0;
    logic        rx_aligned = 1'b1;
    logic        rx_ovfl = 1'b0;
    logic        tx_unfl = 1'b0;
    logic        rx_mf_grant = 1'b1;
    logic [15:0] rx_ret_bd, tx_ret_bd;
    logic [10:0] rx_wr_ofs, tx_rd_ofs;
    logic [7:0]  tx_unseen;
    logic        rx_ret_pop, tx_ret_pop, rx_bd_push, tx_bd_push;
    logic [6:0]  rx_bd_addr, tx_bd_addr;
    logic        rx_mf_alloc, rx_mf_commit, rx_ring_flush, tx_mf_peek, tx_mf_discard;
    logic        rx_ovfl_clr, tx_unfl_clr, rx_crc_bad;
    logic [1:0]  rx_state, tx_state;

    always #5 clk = ~clk;

    // Core and ring models
    int rx_pend = 0, rx_bad = 0, tx_pend = 0;
    int rx_wptr = 0, tx_rptr = 0, tx_lvl = 0;

    assign rx_ret_bd = (rx_pend > 0) ? {1'b1, ((rx_bad > 0) ? 2'b01 : 2'b11), 13'h0} : 16'h0;
    assign tx_ret_bd = (tx_pend > 0) ? {1'b1, 2'b11, 13'h0} : 16'h0;
    assign rx_wr_ofs = 11'(rx_wptr);
    assign tx_rd_ofs = 11'(128 + tx_rptr);
    assign tx_unseen = 8'(tx_lvl);

    always @(posedge clk) begin
        if (rx_ret_pop) begin
            rx_pend <= rx_pend - 1;
            if (rx_bad > 0) rx_bad <= rx_bad - 1;
        end
        if (tx_ret_pop) tx_pend <= tx_pend - 1;
        if (rx_mf_alloc) rx_wptr <= (rx_wptr + 16) % 128;
        if (tx_mf_peek) begin
            tx_rptr <= (tx_rptr + 16) % 128;
            tx_lvl  <= tx_lvl - 16;
        end
    end

    // Strobe monitor, sampled mid-cycle
    int n_rpush = 0, n_tpush = 0, n_commit = 0, n_disc = 0, n_flush = 0;
    int n_rclr = 0, n_tclr = 0, n_crc = 0, n_rpop = 0, n_tpop = 0;
    int last_raddr = -1, last_taddr = -1;

    always @(negedge clk) begin
        if (rx_bd_push) begin n_rpush++; last_raddr = int'(rx_bd_addr); end
        if (tx_bd_push) begin n_tpush++; last_taddr = int'(tx_bd_addr); end
        if (rx_mf_commit) n_commit++;
        if (tx_mf_discard) n_disc++;
        if (rx_ret_pop) n_rpop++;
        if (tx_ret_pop) n_tpop++;
        if (rx_ring_flush) n_flush++;
        if (rx_ovfl_clr) n_rclr++;
        if (tx_unfl_clr) n_tclr++;
        if (rx_crc_bad) n_crc++;
    end

    dsc_top dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
        .rx_aligned(rx_aligned), .rx_ovfl(rx_ovfl), .tx_unfl(tx_unfl),
        .rx_ret_bd(rx_ret_bd), .rx_ret_pop(rx_ret_pop),
        .tx_ret_bd(tx_ret_bd), .tx_ret_pop(tx_ret_pop),
        .rx_mf_grant(rx_mf_grant), .rx_wr_ofs(rx_wr_ofs),
        .tx_unseen(tx_unseen), .tx_rd_ofs(tx_rd_ofs),
        .rx_bd_push(rx_bd_push), .rx_bd_addr(rx_bd_addr),
        .tx_bd_push(tx_bd_push), .tx_bd_addr(tx_bd_addr),
        .rx_mf_alloc(rx_mf_alloc), .rx_mf_commit(rx_mf_commit),
        .rx_ring_flush(rx_ring_flush), .tx_mf_peek(tx_mf_peek),
        .tx_mf_discard(tx_mf_discard), .rx_ovfl_clr(rx_ovfl_clr),
        .tx_unfl_clr(tx_unfl_clr), .rx_crc_bad(rx_crc_bad),
        .rx_state(rx_state), .tx_state(tx_state)
    );

    int n_chk = 0, n_bad = 0;
    int s_rpush, s_tpush, s_commit, s_disc, s_flush, s_rclr, s_tclr, s_crc;

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic snap();
        s_rpush = n_rpush; s_tpush = n_tpush; s_commit = n_commit; s_disc = n_disc;
        s_flush = n_flush; s_rclr = n_rclr; s_tclr = n_tclr; s_crc = n_crc;
    endtask

    task automatic run_pass();
        snap();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        repeat (30) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 reset rx state", int'(rx_state), 0);
        chk("R1 reset tx state", int'(tx_state), 0);
        chk("R1 reset strobes", int'({rx_bd_push, tx_bd_push, rx_ret_pop, rx_ovfl_clr}), 0);
    endtask

    task automatic t_idle_tick();
        run_pass();
        chk("R1 idle tick rx pushes", n_rpush - s_rpush, 0);
        chk("R1 idle tick tx pushes", n_tpush - s_tpush, 0);
        chk("R1 idle tick rx state", int'(rx_state), 0);
    endtask

    task automatic t_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R1 start rx boot", int'(rx_state), 1);
        chk("R1 start tx boot", int'(tx_state), 1);
    endtask

    task automatic t_boot_gate();
        tx_lvl <= 64;
        run_pass();
        chk("R5 gate rx pushes", n_rpush - s_rpush, 0);
        chk("R5 gate tx pushes", n_tpush - s_tpush, 0);
        chk("R5 gate rx state", int'(rx_state), 1);
        chk("R5 gate tx state", int'(tx_state), 1);
    endtask

    task automatic t_boot_run();
        tx_lvl <= 128;
        run_pass();
        chk("R2 boot rx pushes capped", n_rpush - s_rpush, 4);
        chk("R2 boot tx pushes capped", n_tpush - s_tpush, 4);
        chk("R10 rx last addr", last_raddr, 3);
        chk("R10 tx last addr", last_taddr, 11);
        chk("R9 rx clear once", n_rclr - s_rclr, 1);
        chk("R9 tx clear once", n_tclr - s_tclr, 1);
        chk("R9 rx run", int'(rx_state), 2);
        chk("R9 tx run", int'(tx_state), 2);
    endtask

    task automatic t_retire();
        rx_pend <= 2; rx_bad <= 1; tx_pend <= 1;
        run_pass();
        chk("R3 rx commits", n_commit - s_commit, 2);
        chk("R3 tx discards", n_disc - s_disc, 1);
        chk("R4 crc bad once", n_crc - s_crc, 1);
        chk("R11 rx refill same pass", n_rpush - s_rpush, 2);
        chk("R11 tx refill same pass", n_tpush - s_tpush, 1);
        chk("R10 tx addr after refill", last_taddr, 12);
        chk("R9 no clear in run", n_rclr - s_rclr, 0);
    endtask

    task automatic t_full();
        run_pass();
        chk("R2 full no rx push", n_rpush - s_rpush, 0);
        chk("R2 full no tx push", n_tpush - s_tpush, 0);
    endtask

    task automatic t_misalign();
        rx_aligned = 1'b0;
        run_pass();
        chk("R6 misalign recover", int'(rx_state), 3);
        chk("R7 busy no flush", n_flush - s_flush, 0);
        chk("R7 busy no push", n_rpush - s_rpush, 0);
        chk("R7 busy no clear", n_rclr - s_rclr, 0);
        chk("R6 tx unaffected", int'(tx_state), 2);
        rx_aligned = 1'b1;
        rx_pend <= 4;
        run_pass();
        chk("R7 drained commits", n_commit - s_commit, 4);
        chk("R7 drained flush once", n_flush - s_flush, 1);
        chk("R7 drained refill", n_rpush - s_rpush, 4);
        chk("R10 rx wrap addr", last_raddr, 1);
        chk("R9 rx clear after recover", n_rclr - s_rclr, 1);
        chk("R9 rx back to run", int'(rx_state), 2);
    endtask

    task automatic t_no_grant();
        rx_mf_grant = 1'b0;
        rx_pend <= 2;
        run_pass();
        chk("R2 no grant commits", n_commit - s_commit, 2);
        chk("R2 no grant pushes", n_rpush - s_rpush, 0);
        rx_mf_grant = 1'b1;
        run_pass();
        chk("R2 grant back pushes", n_rpush - s_rpush, 2);
        chk("R10 rx addr after grant", last_raddr, 3);
    endtask

    task automatic t_underflow();
        tx_unfl = 1'b1;
        rx_pend <= 1;
        tx_lvl <= 48;
        run_pass();
        chk("R8 underflow recover", int'(tx_state), 3);
        chk("R8 recover gate no tx push", n_tpush - s_tpush, 0);
        chk("R8 recover gate no clear", n_tclr - s_tclr, 0);
        chk("R8 rx still serviced", n_rpush - s_rpush, 1);
        tx_lvl <= 96;
        tx_pend <= 1;
        run_pass();
        chk("R8 prefilled discard", n_disc - s_disc, 1);
        chk("R8 prefilled push", n_tpush - s_tpush, 1);
        chk("R10 tx addr", last_taddr, 13);
        chk("R9 tx clear once", n_tclr - s_tclr, 1);
        chk("R9 tx run", int'(tx_state), 2);
        tx_unfl = 1'b0;
    endtask

    task automatic t_overflow();
        rx_ovfl = 1'b1;
        run_pass();
        chk("R6 overflow recover", int'(rx_state), 3);
        chk("R7 overflow busy no flush", n_flush - s_flush, 0);
        rx_pend <= 4;
        run_pass();
        chk("R7 overflow flush once", n_flush - s_flush, 1);
        chk("R7 overflow refill", n_rpush - s_rpush, 4);
        chk("R9 overflow clear", n_rclr - s_rclr, 1);
        chk("R9 overflow run", int'(rx_state), 2);
        rx_ovfl = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_idle_tick();
        t_start();
        t_boot_gate();
        t_boot_run();
        t_retire();
        t_full();
        t_misalign();
        t_no_grant();
        t_underflow();
        t_overflow();
        finish_run();
    end

endmodule